// File: doc/BRIEF.md
# Interrupt Destination Matcher

This block turns an interrupt send command into a per-target delivery result for a group of `N_TGT` target units. It keeps the high half of a two-word command; writing the low half launches the send. On launch it resolves which targets are addressed and what each selected target must do. Targets can be addressed by physical ID, by logical ID in flat or cluster form, or through a shorthand that bypasses the destination byte. Each target supplies an 8-bit physical ID, an 8-bit logical ID and a 4-bit model field as live configuration inputs.

The result is a target bitmask, one action code common to all selected targets, the vector and the trigger bit. It is presented for exactly one cycle after the launching write. A special INIT form performs no delivery. Instead, it loads each selected target's arbitration ID from its physical ID, and the block holds those IDs and drives them on an output bus. What a target does with a delivered action is handled outside this block.

Top module: `ipi_dest_matcher`

## Requirements
- R1: In physical addressing (command bit 11 = 0, shorthand 0), destination 0xFF selects all targets. Any other destination selects only the lowest-indexed target whose physical ID equals it, or no target if none does.
- R2: In logical addressing (bit 11 = 1), a target whose model field is 0xF matches when the destination AND its logical ID is nonzero.
- R3: In logical addressing, a target whose model field is 0x0 matches when the destination's upper nibble equals the logical ID's upper nibble and the lower nibbles share a set bit. A target with any other model value never matches logically.
- R4: Shorthand (bits 19:18) selects as follows: 0 uses the destination, 1 selects only the target at `sender_idx`, 2 selects all targets, and 3 selects all targets except the one at `sender_idx`.
- R5: Delivery mode (bits 10:8) maps to `res_action` as follows. Mode 0 and mode 7 give 1 (vector post). Mode 2 gives 2 (SMI), mode 4 gives 3 (NMI), mode 5 gives 4 (INIT) and mode 6 gives 5 (startup). Mode 3 gives 0 (nothing) with an empty mask.
- R6: Mode 1 (lowest priority) posts the vector (action 1) to only the lowest-indexed selected target.
- R7: INIT with level bit 14 = 0 and trigger bit 15 = 1 delivers nothing (action 0, empty mask). Each selected target's `arb_id` byte is loaded with its physical ID at the launch edge. Arbitration IDs are 0 after reset and change at no other time.
- R8: Writing the high word (`cmd_hi_sel` = 1) stores only its bits 31:24 as the destination and produces no result. The vector is taken from low-word bits 7:0 and the trigger from bit 15. Both appear on `res_vector` and `res_level_trig`.
- R9: `res_valid` is high in exactly the cycle after each low-word write, including back-to-back writes. Outside a valid cycle, the mask, action, vector and trigger outputs are all 0.
- R10: When the final mask is empty, the action, vector and trigger outputs are 0.
- R11: After reset, all outputs are 0, and the stored destination is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Command word write strobe |
| cmd_hi_sel | input | 1 | 1 writes the high word, 0 writes the low word and launches |
| cmd_wdata | input | 32 | Command word data |
| sender_idx | input | IDX_W | Index of the sending target, used by shorthands |
| tgt_phys_id | input | N_TGT*8 | Physical IDs, target i at bits 8i+7:8i |
| tgt_log_id | input | N_TGT*8 | Logical IDs, same packing |
| tgt_model | input | N_TGT*4 | Model fields, target i at bits 4i+3:4i |
| res_valid | output | 1 | One-cycle result strobe |
| res_mask | output | N_TGT | Selected targets for the action |
| res_action | output | 3 | Action code per R5 |
| res_vector | output | 8 | Vector of the delivered command |
| res_level_trig | output | 1 | Trigger bit of the delivered command |
| arb_id | output | N_TGT*8 | Arbitration IDs, same packing as the physical IDs |

## Verification
A wrong match term or a wrong shorthand decode shows on `res_mask` in the single cycle after the launching write. An error in the lowest-index reduction shows there too, so every send is compared on the cycle it resolves. An arbitration ID corrupted by a stray load persists on `arb_id` until the next INIT-deassert. It is therefore caught on the next compare, even when no send follows. A stale stored destination stays invisible until the next physical or logical send, which then selects the wrong targets.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

  localparam int ID_W    = 8;
  localparam int MODEL_W = 4;

  localparam logic [7:0]   DEST_ALL      = 8'hFF;
  localparam logic [3:0]   MODEL_FLAT    = 4'hF;
  localparam logic [3:0]   MODEL_CLUSTER = 4'h0;

  localparam logic [2:0] DM_FIXED  = 3'd0;
  localparam logic [2:0] DM_LOWPRI = 3'd1;
  localparam logic [2:0] DM_SMI    = 3'd2;
  localparam logic [2:0] DM_NMI    = 3'd4;
  localparam logic [2:0] DM_INIT   = 3'd5;
  localparam logic [2:0] DM_START  = 3'd6;
  localparam logic [2:0] DM_EXT    = 3'd7;

  localparam logic [1:0] SH_DEST    = 2'd0;
  localparam logic [1:0] SH_SELF    = 2'd1;
  localparam logic [1:0] SH_ALL     = 2'd2;
  localparam logic [1:0] SH_OTHERS  = 2'd3;

  typedef enum logic [2:0] {
    ACT_NONE  = 3'd0,
    ACT_POST  = 3'd1,
    ACT_SMI   = 3'd2,
    ACT_NMI   = 3'd3,
    ACT_INIT  = 3'd4,
    ACT_START = 3'd5
  } ipi_action_e;

  typedef struct packed {
    logic [7:0] dest;
    logic [1:0] shorthand;
    logic       trig;
    logic       level;
    logic       log_mode;
    logic [2:0] dmode;
    logic [7:0] vector;
  } ipi_cmd_t;

  // Split the launching low word and stored destination into fields.
  function automatic ipi_cmd_t unpack_cmd(input logic [31:0] lo, input logic [7:0] dest);
    ipi_cmd_t c;
    c.dest      = dest;
    c.shorthand = lo[19:18];
    c.trig      = lo[15];
    c.level     = lo[14];
    c.log_mode  = lo[11];
    c.dmode     = lo[10:8];
    c.vector    = lo[7:0];
    return c;
  endfunction

  function automatic logic flat_hit(input logic [7:0] dest, input logic [7:0] lid);
    return |(dest & lid);
  endfunction

  function automatic logic cluster_hit(input logic [7:0] dest, input logic [7:0] lid);
    return (dest[7:4] == lid[7:4]) && (|(dest[3:0] & lid[3:0]));
  endfunction

  function automatic logic init_deassert(input logic [2:0] dmode, input logic level,
                                         input logic trig);
    return (dmode == DM_INIT) && !level && trig;
  endfunction

  // Delivery mode to action; lowest priority posts, unlisted codes give nothing.
  function automatic ipi_action_e dm_to_action(input logic [2:0] dmode);
    case (dmode)
      DM_FIXED, DM_EXT, DM_LOWPRI: return ACT_POST;
      DM_SMI:                      return ACT_SMI;
      DM_NMI:                      return ACT_NMI;
      DM_INIT:                     return ACT_INIT;
      DM_START:                    return ACT_START;
      default:                     return ACT_NONE;
    endcase
  endfunction

endpackage

// File: rtl/ipi_dest_match.sv
module ipi_dest_match
  import ipi_pkg::*;
#(
  parameter int N_TGT = 8,
  parameter int IDX_W = 3
) (
  input  logic [7:0]               dest,
  input  logic [1:0]               shorthand,
  input  logic                     log_mode,
  input  logic [IDX_W-1:0]         sender_idx,
  input  logic [N_TGT*ID_W-1:0]    tgt_phys_id,
  input  logic [N_TGT*ID_W-1:0]    tgt_log_id,
  input  logic [N_TGT*MODEL_W-1:0] tgt_model,
  output logic [N_TGT-1:0]         sel_mask
);

  localparam logic [N_TGT-1:0] ONE_N = N_TGT'(1);

  logic [N_TGT-1:0] phys_eq;
  logic [N_TGT-1:0] log_hit;
  logic [N_TGT-1:0] is_self;
  logic [N_TGT-1:0] phys_first;
  logic [N_TGT-1:0] phys_mask;

  for (genvar g = 0; g < N_TGT; g++) begin : g_tgt
    logic [ID_W-1:0]    pid;
    logic [ID_W-1:0]    lid;
    logic [MODEL_W-1:0] mdl;
    assign pid = tgt_phys_id[g*ID_W +: ID_W];
    assign lid = tgt_log_id[g*ID_W +: ID_W];
    assign mdl = tgt_model[g*MODEL_W +: MODEL_W];

    assign phys_eq[g] = (pid == dest);
    always_comb begin
      if (mdl == MODEL_FLAT)         log_hit[g] = flat_hit(dest, lid);
      else if (mdl == MODEL_CLUSTER) log_hit[g] = cluster_hit(dest, lid);
      else                           log_hit[g] = 1'b0;
    end
    assign is_self[g] = (sender_idx == IDX_W'(g));
  end

  // Only one target may answer a physical ID: keep the lowest index.
  assign phys_first = phys_eq & (~phys_eq + ONE_N);
  assign phys_mask  = (dest == DEST_ALL) ? '1 : phys_first;

  always_comb begin
    case (shorthand)
      SH_DEST:   sel_mask = log_mode ? log_hit : phys_mask;
      SH_SELF:   sel_mask = is_self;
      SH_ALL:    sel_mask = '1;
      default:   sel_mask = ~is_self;
    endcase
  end

endmodule

// File: rtl/ipi_action_sel.sv
module ipi_action_sel
  import ipi_pkg::*;
#(
  parameter int N_TGT = 8
) (
  input  logic [2:0]       dmode,
  input  logic             level,
  input  logic             trig,
  input  logic [7:0]       vector,
  input  logic [N_TGT-1:0] sel_mask,
  output ipi_action_e      act,
  output logic [N_TGT-1:0] dlv_mask,
  output logic [7:0]       dlv_vector,
  output logic             dlv_trig,
  output logic [N_TGT-1:0] arb_load
);

  localparam logic [N_TGT-1:0] ONE_N = N_TGT'(1);

  logic             deassert;
  logic [N_TGT-1:0] lowest;
  logic [N_TGT-1:0] pre_mask;
  ipi_action_e      pre_act;

  assign deassert = init_deassert(dmode, level, trig);
  assign lowest   = sel_mask & (~sel_mask + ONE_N);
  assign arb_load = deassert ? sel_mask : '0;

  always_comb begin
    pre_act  = dm_to_action(dmode);
    pre_mask = sel_mask;
    if (deassert) begin
      pre_act  = ACT_NONE;
      pre_mask = '0;
    end else if (dmode == DM_LOWPRI) begin
      pre_mask = lowest;
    end else if (pre_act == ACT_NONE) begin
      pre_mask = '0;
    end
  end

  // An empty target set carries nothing at all.
  always_comb begin
    if (pre_mask == '0 || pre_act == ACT_NONE) begin
      act        = ACT_NONE;
      dlv_mask   = '0;
      dlv_vector = '0;
      dlv_trig   = 1'b0;
    end else begin
      act        = pre_act;
      dlv_mask   = pre_mask;
      dlv_vector = vector;
      dlv_trig   = trig;
    end
  end

endmodule

// File: rtl/ipi_arb_bank.sv
module ipi_arb_bank
  import ipi_pkg::*;
#(
  parameter int N_TGT = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N_TGT-1:0]      load,
  input  logic [N_TGT*ID_W-1:0] phys_id,
  output logic [N_TGT*ID_W-1:0] arb_id
);

  for (genvar g = 0; g < N_TGT; g++) begin : g_arb
    logic [ID_W-1:0] arb_q;
    always_ff @(posedge clk) begin
      if (!rst_n)       arb_q <= '0;
      else if (load[g]) arb_q <= phys_id[g*ID_W +: ID_W];
    end
    assign arb_id[g*ID_W +: ID_W] = arb_q;
  end

endmodule

// File: rtl/ipi_dest_matcher.sv
module ipi_dest_matcher
  import ipi_pkg::*;
#(
  parameter int N_TGT = 8,
  localparam int IDX_W = (N_TGT > 1) ? $clog2(N_TGT) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_we,
  input  logic                     cmd_hi_sel,
  input  logic [31:0]              cmd_wdata,
  input  logic [IDX_W-1:0]         sender_idx,
  input  logic [N_TGT*ID_W-1:0]    tgt_phys_id,
  input  logic [N_TGT*ID_W-1:0]    tgt_log_id,
  input  logic [N_TGT*MODEL_W-1:0] tgt_model,
  output logic                     res_valid,
  output logic [N_TGT-1:0]         res_mask,
  output logic [2:0]               res_action,
  output logic [7:0]               res_vector,
  output logic                     res_level_trig,
  output logic [N_TGT*ID_W-1:0]    arb_id
);

  logic [7:0]       dest_q;
  logic             launch;
  logic             hi_write;
  ipi_cmd_t         cmd_c;
  logic [N_TGT-1:0] sel_c;
  ipi_action_e      act_c;
  logic [N_TGT-1:0] mask_c;
  logic [7:0]       vec_c;
  logic             trg_c;
  logic [N_TGT-1:0] arb_load_c;
  logic [N_TGT-1:0] arb_load_g;
  ipi_action_e      act_q;
  logic             ign_unused_bits;

  assign launch   = cmd_we & ~cmd_hi_sel;
  assign hi_write = cmd_we & cmd_hi_sel;
  assign cmd_c    = unpack_cmd(cmd_wdata, dest_q);
  assign ign_unused_bits = ^{cmd_wdata[31:20], cmd_wdata[17:16], cmd_wdata[13:12]};

  ipi_dest_match #(.N_TGT(N_TGT), .IDX_W(IDX_W)) u_match (
    .dest        (cmd_c.dest),
    .shorthand   (cmd_c.shorthand),
    .log_mode    (cmd_c.log_mode),
    .sender_idx  (sender_idx),
    .tgt_phys_id (tgt_phys_id),
    .tgt_log_id  (tgt_log_id),
    .tgt_model   (tgt_model),
    .sel_mask    (sel_c)
  );

  ipi_action_sel #(.N_TGT(N_TGT)) u_act (
    .dmode      (cmd_c.dmode),
    .level      (cmd_c.level),
    .trig       (cmd_c.trig),
    .vector     (cmd_c.vector),
    .sel_mask   (sel_c),
    .act        (act_c),
    .dlv_mask   (mask_c),
    .dlv_vector (vec_c),
    .dlv_trig   (trg_c),
    .arb_load   (arb_load_c)
  );

  assign arb_load_g = launch ? arb_load_c : '0;

  ipi_arb_bank #(.N_TGT(N_TGT)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (arb_load_g),
    .phys_id (tgt_phys_id),
    .arb_id  (arb_id)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)        dest_q <= '0;
    else if (hi_write) dest_q <= cmd_wdata[31:24];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid      <= 1'b0;
      res_mask       <= '0;
      act_q          <= ACT_NONE;
      res_vector     <= '0;
      res_level_trig <= 1'b0;
    end else if (launch) begin
      res_valid      <= 1'b1;
      res_mask       <= mask_c;
      act_q          <= act_c;
      res_vector     <= vec_c;
      res_level_trig <= trg_c;
    end else begin
      res_valid      <= 1'b0;
      res_mask       <= '0;
      act_q          <= ACT_NONE;
      res_vector     <= '0;
      res_level_trig <= 1'b0;
    end
  end

  assign res_action = act_q;

endmodule

// File: rtl/ipi_dest_matcher_chk.sv
module ipi_dest_matcher_chk #(
  parameter int N_TGT = 8,
  parameter int IDX_W = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               launch,
  input logic [2:0]         cmd_dmode,
  input logic [1:0]         cmd_sh,
  input logic               cmd_level,
  input logic               cmd_trig,
  input logic [IDX_W-1:0]   sender_idx,
  input logic               res_valid,
  input logic [N_TGT-1:0]   res_mask,
  input logic [2:0]         res_action,
  input logic [7:0]         res_vector,
  input logic               res_level_trig,
  input logic [N_TGT*8-1:0] arb_id
);

  logic             prev_launch;
  logic [2:0]       prev_dmode;
  logic [1:0]       prev_sh;
  logic             prev_deassert;
  logic [IDX_W-1:0] prev_sender;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_launch   <= 1'b0;
      prev_dmode    <= '0;
      prev_sh       <= '0;
      prev_deassert <= 1'b0;
      prev_sender   <= '0;
    end else begin
      prev_launch   <= launch;
      prev_dmode    <= cmd_dmode;
      prev_sh       <= cmd_sh;
      prev_deassert <= (cmd_dmode == 3'd5) && !cmd_level && cmd_trig;
      prev_sender   <= sender_idx;
    end
  end

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> (res_mask == '0 && res_action == 3'd0 && res_vector == 8'd0 && !res_level_trig));

  assert_empty_none_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_action != 3'd0) |-> (res_mask != '0));

  assert_none_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_action == 3'd0) |-> (res_mask == '0));

  assert_lowpri_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && prev_launch && prev_dmode == 3'd1) |-> $onehot0(res_mask));

  assert_self_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && prev_launch && prev_sh == 2'd1) |-> ($countones(res_mask) <= 1));

  assert_others_skip_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && prev_launch && prev_sh == 2'd3 && int'(prev_sender) < N_TGT)
      |-> !res_mask[prev_sender]);

  assert_deassert_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && prev_launch && prev_deassert) |-> (res_action == 3'd0));

  assert_arb_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !prev_launch |-> $stable(arb_id));

  assert_mode3_none_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && prev_launch && prev_dmode == 3'd3) |-> (res_action == 3'd0));

endmodule

bind ipi_dest_matcher ipi_dest_matcher_chk #(.N_TGT(N_TGT), .IDX_W(IDX_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .launch         (launch),
  .cmd_dmode      (cmd_wdata[10:8]),
  .cmd_sh         (cmd_wdata[19:18]),
  .cmd_level      (cmd_wdata[14]),
  .cmd_trig       (cmd_wdata[15]),
  .sender_idx     (sender_idx),
  .res_valid      (res_valid),
  .res_mask       (res_mask),
  .res_action     (res_action),
  .res_vector     (res_vector),
  .res_level_trig (res_level_trig),
  .arb_id         (arb_id)
);

// File: tb/tb_ipi_dest_matcher.sv
module tb_ipi_dest_matcher;
  localparam int N = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_we = 1'b0;
  logic          cmd_hi_sel = 1'b0;
  logic [31:0]   cmd_wdata = '0;
  logic [2:0]    sender_idx = '0;
  logic [N*8-1:0] tgt_phys_id;
  logic [N*8-1:0] tgt_log_id;
  logic [N*4-1:0] tgt_model;
  logic          res_valid;
  logic [N-1:0]  res_mask;
  logic [2:0]    res_action;
  logic [7:0]    res_vector;
  logic          res_level_trig;
  logic [N*8-1:0] arb_id;

  ipi_dest_matcher #(.N_TGT(N)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_hi_sel(cmd_hi_sel),
    .cmd_wdata(cmd_wdata), .sender_idx(sender_idx), .tgt_phys_id(tgt_phys_id),
    .tgt_log_id(tgt_log_id), .tgt_model(tgt_model), .res_valid(res_valid),
    .res_mask(res_mask), .res_action(res_action), .res_vector(res_vector),
    .res_level_trig(res_level_trig), .arb_id(arb_id)
  );

  always #4 clk = ~clk;

  int    checks = 0;
  int    errors = 0;
  bit    done = 0;
  string cur_req = "R11";

  // Reference state
  logic [7:0]   m_dest;
  logic [N*8-1:0] m_arb;
  logic         e_valid;
  logic [N-1:0] e_mask;
  logic [2:0]   e_action;
  logic [7:0]   e_vector;
  logic         e_trig;

  function automatic logic [7:0] byte_of(logic [N*8-1:0] v, int i);
    return v[i*8 +: 8];
  endfunction

  task automatic model_launch(input logic [31:0] lo);
    logic [N-1:0] sel = '0;
    logic [1:0] sh = lo[19:18];
    logic [2:0] dm = lo[10:8];
    int act = 0;
    if (sh == 2'd0) begin
      if (!lo[11]) begin
        if (m_dest == 8'hFF) sel = '1;
        else begin
          for (int i = 0; i < N; i++)
            if (sel == '0 && byte_of(tgt_phys_id, i) == m_dest) sel[i] = 1'b1;
        end
      end else begin
        for (int i = 0; i < N; i++) begin
          logic [7:0] l = byte_of(tgt_log_id, i);
          logic [3:0] md = tgt_model[i*4 +: 4];
          if (md == 4'hF && (m_dest & l) != 0) sel[i] = 1'b1;
          if (md == 4'h0 && m_dest[7:4] == l[7:4] && (m_dest[3:0] & l[3:0]) != 0) sel[i] = 1'b1;
        end
      end
    end else if (sh == 2'd1) sel[sender_idx] = 1'b1;
    else if (sh == 2'd2) sel = '1;
    else begin sel = '1; sel[sender_idx] = 1'b0; end

    if (dm == 3'd5 && !lo[14] && lo[15]) begin
      for (int i = 0; i < N; i++) if (sel[i]) m_arb[i*8 +: 8] = byte_of(tgt_phys_id, i);
      sel = '0;
      act = 0;
    end else begin
      case (dm)
        3'd0, 3'd7: act = 1;
        3'd1: begin
          act = 1;
          for (int i = 0; i < N; i++)
            if (sel[i]) begin sel = '0; sel[i] = 1'b1; break; end
        end
        3'd2: act = 2;
        3'd4: act = 3;
        3'd5: act = 4;
        3'd6: act = 5;
        default: act = 0;
      endcase
    end
    if (act == 0 || sel == '0) begin
      e_mask = '0; e_action = 0; e_vector = 0; e_trig = 0;
    end else begin
      e_mask = sel; e_action = 3'(act); e_vector = lo[7:0]; e_trig = lo[15];
    end
    e_valid = 1'b1;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_dest = 0; m_arb = '0;
      e_valid = 0; e_mask = 0; e_action = 0; e_vector = 0; e_trig = 0;
    end else begin
      e_valid = 0; e_mask = 0; e_action = 0; e_vector = 0; e_trig = 0;
      if (cmd_we && cmd_hi_sel) m_dest = cmd_wdata[31:24];
      else if (cmd_we) model_launch(cmd_wdata);
    end
  end

  task automatic chk(input string req, input string nm, input logic [63:0] a, input logic [63:0] e);
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, nm, a, e, $time);
    end
  endtask

  // Compare every cycle, away from the active edge.
  always @(negedge clk) begin
    if (!done) begin
      string r = rst_n ? cur_req : "R11";
      chk(rst_n ? "R9" : "R11", "valid", 64'(res_valid), 64'(e_valid));
      chk(r, "mask", 64'(res_mask), 64'(e_mask));
      chk(r, "action", 64'(res_action), 64'(e_action));
      chk(rst_n ? "R8" : "R11", "vector", 64'(res_vector), 64'(e_vector));
      chk(rst_n ? "R8" : "R11", "trig", 64'(res_level_trig), 64'(e_trig));
      chk(rst_n ? "R7" : "R11", "arb_id", arb_id, m_arb);
    end
  end

  function automatic logic [31:0] mk(input logic [7:0] vec, input logic [2:0] dm,
      input logic lm, input logic lvl, input logic trg, input logic [1:0] sh);
    return {12'd0, sh, 2'd0, trg, lvl, 2'd0, lm, dm, vec};
  endfunction

  task automatic wr_hi(input logic [7:0] d);
    @(negedge clk);
    cmd_we = 1; cmd_hi_sel = 1; cmd_wdata = {d, 24'h00ABCD};
    @(negedge clk);
    cmd_we = 0;
  endtask

  task automatic wr_lo(input logic [31:0] w);
    @(negedge clk);
    cmd_we = 1; cmd_hi_sel = 0; cmd_wdata = w;
    @(negedge clk);
    cmd_we = 0;
  endtask

  task automatic send(input string req, input logic [7:0] d, input logic [31:0] w);
    cur_req = req;
    wr_hi(d);
    wr_lo(w);
    @(negedge clk);
  endtask

  initial begin
    // Targets: duplicate physical ID at 2 and 5; flat 0..3, cluster 4..6, other model 7.
    for (int i = 0; i < N; i++) tgt_phys_id[i*8 +: 8] = 8'h10 + 8'(i);
    tgt_phys_id[5*8 +: 8] = 8'h12;
    tgt_log_id = {8'hFF, 8'h31, 8'h22, 8'h21, 8'h0C, 8'h04, 8'h02, 8'h01};
    tgt_model  = {4'h5, 4'h0, 4'h0, 4'h0, 4'hF, 4'hF, 4'hF, 4'hF};

    repeat (3) @(negedge clk);
    rst_n = 1;
    cur_req = "R8";
    wr_hi(8'h13);               // R8: store only, no result
    repeat (2) @(negedge clk);

    send("R1", 8'h13, mk(8'h40, 3'd0, 0, 1, 0, 2'd0));
    send("R1", 8'hFF, mk(8'h41, 3'd0, 0, 1, 1, 2'd0));
    send("R1", 8'h12, mk(8'h42, 3'd0, 0, 1, 0, 2'd0));
    send("R10", 8'h55, mk(8'h43, 3'd0, 0, 1, 0, 2'd0));
    send("R2", 8'h05, mk(8'h44, 3'd0, 1, 1, 0, 2'd0));
    send("R3", 8'h23, mk(8'h45, 3'd0, 1, 1, 0, 2'd0));
    send("R3", 8'h3F, mk(8'h46, 3'd0, 1, 1, 0, 2'd0));
    send("R3", 8'h40, mk(8'h47, 3'd0, 1, 1, 0, 2'd0));
    sender_idx = 3'd2;
    for (int s = 1; s < 4; s++) send("R4", 8'h11, mk(8'h50, 3'd0, 0, 1, 0, 2'(s)));
    sender_idx = 3'd7;
    send("R4", 8'h11, mk(8'h51, 3'd2, 0, 1, 0, 2'd3));
    for (int m = 0; m < 8; m++) send("R5", 8'hFF, mk(8'h60 + 8'(m), 3'(m), 0, 1, 1, 2'd0));
    send("R6", 8'h0C, mk(8'h70, 3'd1, 1, 1, 0, 2'd0));
    send("R6", 8'hFF, mk(8'h71, 3'd1, 0, 1, 0, 2'd3));
    send("R7", 8'hFF, mk(8'h00, 3'd5, 0, 1, 1, 2'd0));  // level 1: ordinary INIT
    send("R7", 8'hFF, mk(8'h00, 3'd5, 0, 0, 1, 2'd0));  // deassert to all
    for (int i = 0; i < N; i++) tgt_phys_id[i*8 +: 8] = 8'h80 + 8'(i);
    send("R7", 8'h23, mk(8'h00, 3'd5, 1, 0, 1, 2'd0));  // deassert to cluster subset
    // R9: back-to-back launches
    cur_req = "R9";
    @(negedge clk);
    cmd_we = 1; cmd_hi_sel = 0; cmd_wdata = mk(8'h90, 3'd0, 0, 1, 0, 2'd2);
    @(negedge clk);
    cmd_wdata = mk(8'h91, 3'd4, 0, 1, 0, 2'd1);
    @(negedge clk);
    cmd_we = 0;
    repeat (2) @(negedge clk);

    cur_req = "R5";
    for (int k = 0; k < 400; k++) begin
      logic [31:0] w = $urandom;
      sender_idx = 3'($urandom);
      if (k % 7 == 0) tgt_model[($urandom % N)*4 +: 4] = ($urandom % 2) ? 4'hF : 4'h0;
      send("R5", 8'($urandom), w);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule